// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear Option

This block is the watchdog counter of a small microcontroller core. It counts ticks from one of three selectable tick sources and signals a time-out when the count wraps past all ones. When the core is running, a time-out asks for a full device reset. When the core is in power-down, a time-out instead asks the core to wake up and to reset only its program counter and stack pointer. In both cases a sticky time-out flag is set.

The core keeps the counter from expiring with software clear commands, and a HALT command also clears it. A static mode input selects how the software clear works. In single mode, one clear strobe is enough. In paired mode, two different clear strobes must arrive in alternation, and a strobe that repeats the half already pending does nothing. The external active-low reset clears everything. A second static input turns the whole watchdog off.

Top module: `wdog_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, the pair tracker and all four outputs are cleared. After that edge, every output reads 0.
- R2: With `power_down` low, the 2^(PRESC_W+CNT_W)-th counted tick after a clear makes `reset_req` high for exactly one cycle, in the cycle after that tick's edge, and sets `to_flag`.
- R3: With `power_down` high, a time-out makes `wake_req` and `part_reset_req` high for one cycle instead, leaves `reset_req` low, and sets `to_flag`.
- R4: With `cfg_pair_mode` = 0, a `clr_single` strobe clears the counter. `clr_first` and `clr_second` have no effect in this mode.
- R5: With `cfg_pair_mode` = 1, the counter clears only in the cycle that completes a pair: `clr_second` after a pending `clr_first`, `clr_first` after a pending `clr_second`, or both strobes in the same cycle. The tracker then returns to idle. `clr_single` has no effect in this mode.
- R6: In paired mode, a repeat of the strobe that is already pending is ignored, and the pending half stays pending.
- R7: A `halt_cmd` strobe clears the counter in either mode.
- R8: With `cfg_enable` = 0, the counter holds at zero and no time-out occurs. After the watchdog is enabled, a full period is needed before the next time-out.
- R9: `cfg_src` selects the counted tick: 0 = `tick_osc`, 1 = every fourth `tick_sys` pulse, 2 = `tick_rtc`, 3 = no tick. Unselected tick inputs are not counted.
- R10: `to_flag` stays high until `rst_n` is low or `to_flag_clr` is high. A time-out in the same cycle as `to_flag_clr` leaves the flag set.
- R11: After a time-out the counter restarts from zero, so the next time-out comes a full period later.
- R12: A clear in the same cycle as the final tick of a period wins: no time-out occurs, and the count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | External reset, active low, synchronous |
| cfg_enable | input | 1 | Static watchdog enable |
| cfg_pair_mode | input | 1 | Static clear mode: 0 single strobe, 1 alternating pair |
| cfg_src | input | 2 | Static tick source select |
| tick_osc | input | 1 | Tick from the watchdog oscillator |
| tick_sys | input | 1 | System clock enable, divided by four inside the block |
| tick_rtc | input | 1 | Tick from the real-time clock |
| clr_single | input | 1 | Single-mode clear strobe |
| clr_first | input | 1 | Paired-mode clear strobe, first kind |
| clr_second | input | 1 | Paired-mode clear strobe, second kind |
| halt_cmd | input | 1 | HALT strobe, clears the counter |
| power_down | input | 1 | High while the core is powered down |
| to_flag_clr | input | 1 | Core request to clear the time-out flag |
| reset_req | output | 1 | One-cycle full reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| part_reset_req | output | 1 | One-cycle request to reset only the program counter and stack pointer |
| to_flag | output | 1 | Sticky time-out flag |

## Verification
The bench goes after the paired-clear rules. It repeats the same half of a pair, sends the pair in both orders and sends stray strobes from the other mode. A tracker that accepted a repeat would clear early and hide a time-out that is due. It also places a clear on the very last tick of a period, where a design that lets the tick win would fire a reset that should not happen. It checks that a time-out during power-down raises only the wake path, and that the flag survives a clear request that arrives together with a new time-out. Tick counts one short of and exactly at a period, on every source, catch an off-by-one counter or a wrong divider.

// File: rtl/wdog_pkg.sv
// Shared types for the watchdog block.
// Assumes: encodings below are fixed by the port-level contract (cfg_src).
package wdog_pkg;

    // Tick source selection codes (cfg_src)
    typedef enum logic [1:0] {
        SRC_OSC  = 2'd0,
        SRC_SYS4 = 2'd1,
        SRC_RTC  = 2'd2,
        SRC_NONE = 2'd3
    } tick_src_e;

    // Paired-clear tracker states
    typedef enum logic [1:0] {
        PAIR_IDLE   = 2'd0,
        PAIR_HAVE_A = 2'd1,
        PAIR_HAVE_B = 2'd2
    } pair_st_e;

endpackage

// File: rtl/wdog_tick_sel.sv
// Picks the counted tick from three sources. The system-clock enable
// is divided by 2**DIV_W before use.
// Assumes: all tick inputs are single-cycle enables synchronous to clk.
module wdog_tick_sel
    import wdog_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       tick_osc,
    input  logic       tick_sys,
    input  logic       tick_rtc,
    output logic       tick
);

    logic [DIV_W-1:0] div_cnt;
    logic             sys_div_tick;

    // Divide the system-clock enable down by counting its pulses
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (tick_sys)
            div_cnt <= div_cnt + 1'b1;
    end

    assign sys_div_tick = tick_sys && (&div_cnt);

    // Route the selected source to the counter
    always_comb begin
        unique case (tick_src_e'(src))
            SRC_OSC:  tick = tick_osc;
            SRC_SYS4: tick = sys_div_tick;
            SRC_RTC:  tick = tick_rtc;
            default:  tick = 1'b0;
        endcase
    end

    // R9
    sys_div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_div_tick |=> (div_cnt == '0));

endmodule

// File: rtl/wdog_clear_ctl.sv
// Turns software clear strobes into one clear pulse. In single mode a
// single strobe clears; in paired mode the two kinds must alternate.
// Assumes: strobes are one-cycle pulses; mode is static after reset.
module wdog_clear_ctl
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pair_mode,
    input  logic clr_single,
    input  logic clr_first,
    input  logic clr_second,
    output logic sw_clear
);

    pair_st_e st, st_nx;
    logic     pair_done;

    // Decide pair completion and the next tracker state
    always_comb begin
        st_nx     = st;
        pair_done = 1'b0;
        if (pair_mode) begin
            unique case (st)
                PAIR_IDLE: begin
                    if (clr_first && clr_second) pair_done = 1'b1;
                    else if (clr_first)          st_nx = PAIR_HAVE_A;
                    else if (clr_second)         st_nx = PAIR_HAVE_B;
                end
                PAIR_HAVE_A: if (clr_second) pair_done = 1'b1;
                PAIR_HAVE_B: if (clr_first)  pair_done = 1'b1;
                default:     st_nx = PAIR_IDLE;
            endcase
            if (pair_done) st_nx = PAIR_IDLE;
        end else begin
            st_nx = PAIR_IDLE;
        end
    end

    // Hold the tracker state
    always_ff @(posedge clk) begin
        if (!rst_n) st <= PAIR_IDLE;
        else        st <= st_nx;
    end

    assign sw_clear = pair_mode ? pair_done : clr_single;

    // R6
    repeat_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode && st == PAIR_HAVE_A && clr_first && !clr_second)
            |=> (st == PAIR_HAVE_A));
    // R6
    repeat_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode && st == PAIR_HAVE_B && clr_second && !clr_first)
            |=> (st == PAIR_HAVE_B));
    // R5
    pair_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode && sw_clear) |=> (st == PAIR_IDLE));

endmodule

// File: rtl/wdog_counter.sv
// Prescaler and watchdog count held as one up-counter. Raises ovf in
// the cycle whose tick wraps it from all ones.
// Assumes: clr has priority over tick; en is static.
module wdog_counter #(
    parameter int PRESC_W = 3,
    parameter int CNT_W   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic clr,
    output logic ovf
);

    localparam int W = PRESC_W + CNT_W;

    logic [W-1:0] cnt;

    // Count ticks, clearing on reset, disable or clear request
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    assign ovf = en && tick && !clr && (&cnt);

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R11
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == '0));
    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

endmodule

// File: rtl/wdog_top.sv
// Watchdog top: tick select, clear control, counter and the
// registered request outputs with the sticky time-out flag.
// Assumes: configuration inputs are static while rst_n is high.
module wdog_top #(
    parameter int PRESC_W = 3,
    parameter int CNT_W   = 5,
    parameter int DIV_W   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_enable,
    input  logic       cfg_pair_mode,
    input  logic [1:0] cfg_src,
    input  logic       tick_osc,
    input  logic       tick_sys,
    input  logic       tick_rtc,
    input  logic       clr_single,
    input  logic       clr_first,
    input  logic       clr_second,
    input  logic       halt_cmd,
    input  logic       power_down,
    input  logic       to_flag_clr,
    output logic       reset_req,
    output logic       wake_req,
    output logic       part_reset_req,
    output logic       to_flag
);

    logic tick_w, sw_clear_w, ovf_w;

    wdog_tick_sel #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (cfg_src),
        .tick_osc (tick_osc),
        .tick_sys (tick_sys),
        .tick_rtc (tick_rtc),
        .tick     (tick_w)
    );

    wdog_clear_ctl u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_mode  (cfg_pair_mode),
        .clr_single (clr_single),
        .clr_first  (clr_first),
        .clr_second (clr_second),
        .sw_clear   (sw_clear_w)
    );

    wdog_counter #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_enable),
        .tick  (tick_w),
        .clr   (sw_clear_w || halt_cmd),
        .ovf   (ovf_w)
    );

    // Register the time-out outcome and keep the sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req      <= 1'b0;
            wake_req       <= 1'b0;
            part_reset_req <= 1'b0;
            to_flag        <= 1'b0;
        end else begin
            reset_req      <= ovf_w && !power_down;
            wake_req       <= ovf_w && power_down;
            part_reset_req <= ovf_w && power_down;
            if (ovf_w)            to_flag <= 1'b1;
            else if (to_flag_clr) to_flag <= 1'b0;
        end
    end

    // R2
    reset_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(!power_down));
    // R3
    wake_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(power_down));
    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_w |=> to_flag);
    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag_clr && !ovf_w) |=> !to_flag);
    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!reset_req && !wake_req));

endmodule

// File: tb/test_wdog_top.sv
`timescale 1ns/1ps
module test_wdog_top;

    localparam int PW = 3;
    localparam int CW = 5;
    localparam int N  = 1 << (PW + CW);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b1, cfg_pair_mode = 1'b0;
    logic [1:0] cfg_src = 2'd0;
    logic       tick_osc = 1'b0, tick_sys = 1'b0, tick_rtc = 1'b0;
    logic       clr_single = 1'b0, clr_first = 1'b0, clr_second = 1'b0;
    logic       halt_cmd = 1'b0, power_down = 1'b0, to_flag_clr = 1'b0;
    logic       reset_req, wake_req, part_reset_req, to_flag;

    logic [1:0] line = 2'd0;
    int n_tests = 0, n_fail = 0;
    int n_rst = 0, n_wake = 0, n_part = 0;

    always #2.5 clk = ~clk;

    wdog_top #(.PRESC_W(PW), .CNT_W(CW)) i_wdog_top (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_pair_mode(cfg_pair_mode), .cfg_src(cfg_src),
        .tick_osc(tick_osc), .tick_sys(tick_sys), .tick_rtc(tick_rtc),
        .clr_single(clr_single), .clr_first(clr_first), .clr_second(clr_second),
        .halt_cmd(halt_cmd), .power_down(power_down), .to_flag_clr(to_flag_clr),
        .reset_req(reset_req), .wake_req(wake_req),
        .part_reset_req(part_reset_req), .to_flag(to_flag)
    );

    // Count request pulses shortly after each rising edge
    always @(posedge clk) begin
        #1;
        if (reset_req)      n_rst++;
        if (wake_req)       n_wake++;
        if (part_reset_req) n_part++;
    end

    typedef struct packed {
        logic [1:0]  src;
        logic [1:0]  line;
        logic [15:0] pulses;
        logic        exp;
    } vec_t;

    // R9 tick source vectors
    localparam vec_t VEC [8] = '{
        '{2'd0, 2'd0, 16'(N),       1'b1},
        '{2'd0, 2'd0, 16'(N-1),     1'b0},
        '{2'd0, 2'd2, 16'(N),       1'b0},
        '{2'd1, 2'd1, 16'(4*N),     1'b1},
        '{2'd1, 2'd1, 16'(4*N-1),   1'b0},
        '{2'd2, 2'd2, 16'(N),       1'b1},
        '{2'd2, 2'd0, 16'(N),       1'b0},
        '{2'd3, 2'd0, 16'(N),       1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic one(input logic tk, input logic cs, input logic c1,
                       input logic c2, input logic hl, input logic fc);
        @(negedge clk);
        tick_osc    = tk && (line == 2'd0);
        tick_sys    = tk && (line == 2'd1);
        tick_rtc    = tk && (line == 2'd2);
        clr_single  = cs;
        clr_first   = c1;
        clr_second  = c2;
        halt_cmd    = hl;
        to_flag_clr = fc;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) one(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic settle();
        for (int i = 0; i < 3; i++) one(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset(input logic pair);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_pair_mode = pair;
        settle();
        rst_n = 1'b1;
        settle();
        n_rst = 0; n_wake = 0; n_part = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        // R9: walk the source vector table
        foreach (VEC[k]) begin
            cfg_src = VEC[k].src;
            line    = VEC[k].line;
            do_reset(1'b0);
            ticks(int'(VEC[k].pulses));
            settle();
            chk($sformatf("R9 row %0d", k), n_rst, int'(VEC[k].exp));
        end
        cfg_src = 2'd0; line = 2'd0;

        // R1: reset state
        do_reset(1'b0);
        chk("R1 outputs", {reset_req, wake_req, part_reset_req, to_flag}, 0);

        // R2: running time-out
        ticks(N-1); settle();
        chk("R2 before period", n_rst, 0);
        ticks(1); settle();
        chk("R2 at period", n_rst, 1);
        chk("R2 flag", to_flag, 1);
        chk("R2 no wake", n_wake, 0);

        // R11: restart after wrap
        ticks(N-1); settle();
        chk("R11 before second", n_rst, 1);
        ticks(1); settle();
        chk("R11 second", n_rst, 2);

        // R10: flag sticky, clearable, set wins
        chk("R10 sticky", to_flag, 1);
        one(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); settle();
        chk("R10 cleared", to_flag, 0);
        ticks(N-1);
        one(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); settle();
        chk("R10 set wins", to_flag, 1);

        // R3: power-down time-out
        do_reset(1'b0);
        power_down = 1'b1;
        ticks(N); settle();
        chk("R3 wake", n_wake, 1);
        chk("R3 partial", n_part, 1);
        chk("R3 no reset", n_rst, 0);
        chk("R3 flag", to_flag, 1);
        power_down = 1'b0;

        // R4: single mode clear, pair strobes ignored
        do_reset(1'b0);
        ticks(N-1);
        one(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        ticks(N-1); settle();
        chk("R4 cleared", n_rst, 0);
        ticks(1); settle();
        chk("R4 period after clear", n_rst, 1);
        do_reset(1'b0);
        ticks(N-1);
        one(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        ticks(1); settle();
        chk("R4 pair strobes ignored", n_rst, 1);

        // R5: paired clear, single strobe ignored
        do_reset(1'b1);
        ticks(N-1);
        one(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        ticks(1); settle();
        chk("R5 single ignored", n_rst, 1);
        do_reset(1'b1);
        ticks(10);
        one(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        ticks(10);
        one(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        ticks(N-1); settle();
        chk("R5 first then second", n_rst, 0);
        ticks(1); settle();
        chk("R5 period after pair", n_rst, 1);
        do_reset(1'b1);
        ticks(10);
        one(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        ticks(10);
        one(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        ticks(N-1); settle();
        chk("R5 second then first", n_rst, 0);

        // R6: repeated half ignored
        do_reset(1'b1);
        one(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        ticks(N-10);
        one(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        ticks(10); settle();
        chk("R6 repeat first", n_rst, 1);
        do_reset(1'b1);
        one(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        ticks(N-10);
        one(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        ticks(10); settle();
        chk("R6 repeat second", n_rst, 1);

        // R7: HALT clears
        do_reset(1'b0);
        ticks(N-1);
        one(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        ticks(N-1); settle();
        chk("R7 halt cleared", n_rst, 0);
        ticks(1); settle();
        chk("R7 period after halt", n_rst, 1);

        // R8: disabled holds
        do_reset(1'b0);
        cfg_enable = 1'b0;
        ticks(2*N); settle();
        chk("R8 no time-out", n_rst, 0);
        chk("R8 no flag", to_flag, 0);
        cfg_enable = 1'b1;
        ticks(N-1); settle();
        chk("R8 held at zero", n_rst, 0);
        ticks(1); settle();
        chk("R8 after enable", n_rst, 1);

        // R12: clear on the final tick wins
        do_reset(1'b0);
        ticks(N-1);
        one(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        ticks(N-1); settle();
        chk("R12 clear wins", n_rst, 0);
        ticks(1); settle();
        chk("R12 period from zero", n_rst, 1);

        summary();
    end

endmodule